// File: doc/BRIEF.md
# Readout Slice Frame Formatter

The block takes one event's readout content and sends it out as a stream of 20-bit slices. The content is three parts: an 80-bit record from each of 20 serialiser channels, a 48-bit hit word and a 12-bit bunch-crossing number. A single start pulse copies all three into internal registers. The block then presents one slice per accepted beat on a valid/ready output bus until the whole event has gone.

The 80 slices of the channel section come first. Each is a bit-column across the channels: output bit i carries channel i. After them come three packed trailer slices that interleave hit bits and bunch-crossing bits. A busy level covers the whole transfer. A one-cycle done pulse marks its end, and a new event may be started in that same cycle.

Top module: `rdo_slice_fmt`

## Requirements
- R1: After reset, slc_valid_o, busy_o and done_o are all low.
- R2: A start_i seen while idle captures ser_data_i, hit_i and bcn_i. From the next cycle busy_o and slc_valid_o are high and slice 0 is presented.
- R3: Slice k, for k from 0 to 79, carries bit k of channel i on output bit i. Channel i occupies ser_data_i[80i+79:80i].
- R4: Slices 80, 81 and 82 are trailer slices j = 0, 1, 2. Bits [15:0] of trailer slice j hold hit_i[16j+15:16j] and bits [19:16] hold bcn_i[4j+3:4j]. Every event is exactly 83 slices.
- R5: While slc_valid_o is high and slc_ready_i is low, slc_data_o and slc_valid_o hold their values.
- R6: The slice position moves forward only on a cycle in which slc_valid_o and slc_ready_i are both high.
- R7: A start_i that arrives while busy_o is high does not restart or change the current transfer. This includes the cycle in which slice 82 is accepted.
- R8: In the cycle after slice 82 is accepted, done_o is high for exactly one cycle, while busy_o and slc_valid_o are low.
- R9: Changes on ser_data_i, hit_i or bcn_i after the start cycle do not affect the slices of the current event.
- R10: A start_i in the cycle in which done_o is high is accepted, and slice 0 of the new event appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to capture and send one event |
| ser_data_i | input | 1600 | 20 channel records of 80 bits; channel i at [80i+79:80i] |
| hit_i | input | 48 | Hit-merger word |
| bcn_i | input | 12 | Bunch-crossing number |
| slc_ready_i | input | 1 | Downstream accepts the presented slice |
| slc_data_o | output | 20 | Current slice |
| slc_valid_o | output | 1 | Slice is presented |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after the last slice is accepted |

## Verification
Two functions can fall in the same cycle here: the end-of-event done pulse and the acceptance of a new start. A closely related case is a start arriving on the same edge that accepts slice 82. The bench provokes both by holding start_i high across the end of a transfer. The reference model must ignore the request while the last slice is being taken, then accept it in the done cycle and expect slice 0 of the fresh capture one cycle later. A mismatch in either direction shows up as a wrong busy, valid or data value on that cycle.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } fmt_state_e;
endpackage

// File: rtl/rdo_rst_sync.sv
module rdo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rdo_event_capture.sv
module rdo_event_capture #(
  parameter int N_CH  = 20,
  parameter int REC_W = 80,
  parameter int HIT_W = 48,
  parameter int BCN_W = 12
) (
  input  logic                    clk,
  input  logic                    load_i,
  input  logic [N_CH*REC_W-1:0]   ser_i,
  input  logic [HIT_W-1:0]        hit_i,
  input  logic [BCN_W-1:0]        bcn_i,
  output logic [N_CH*REC_W-1:0]   rec_o,
  output logic [HIT_W-1:0]        hit_o,
  output logic [BCN_W-1:0]        bcn_o
);
  // Data registers carry no reset: they are only read while a transfer runs,
  // and every transfer starts with a load.
  genvar ch;
  generate
    for (ch = 0; ch < N_CH; ch++) begin : g_ch
      logic [REC_W-1:0] rec_q;
      always_ff @(posedge clk) begin
        if (load_i) rec_q <= ser_i[ch*REC_W +: REC_W];
      end
      assign rec_o[ch*REC_W +: REC_W] = rec_q;
    end
  endgenerate

  logic [HIT_W-1:0] hit_q;
  logic [BCN_W-1:0] bcn_q;

  always_ff @(posedge clk) begin
    if (load_i) begin
      hit_q <= hit_i;
      bcn_q <= bcn_i;
    end
  end

  assign hit_o = hit_q;
  assign bcn_o = bcn_q;
endmodule

// File: rtl/rdo_slice_select.sv
module rdo_slice_select #(
  parameter int N_CH    = 20,
  parameter int REC_W   = 80,
  parameter int HIT_W   = 48,
  parameter int BCN_W   = 12,
  parameter int HIT_PER = 16,
  parameter int BCN_PER = 4,
  parameter int IDX_W   = 7
) (
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [N_CH*REC_W-1:0]   rec_i,
  input  logic [HIT_W-1:0]        hit_i,
  input  logic [BCN_W-1:0]        bcn_i,
  output logic [N_CH-1:0]         slice_o
);
  localparam int N_MRG = HIT_W / HIT_PER;

  logic [N_CH-1:0] col_slc;
  logic [N_CH-1:0] mrg_slc [N_MRG];

  // Column slices: one bit from each channel record.
  genvar ch;
  generate
    for (ch = 0; ch < N_CH; ch++) begin : g_col
      logic [REC_W-1:0] ch_rec;
      assign ch_rec      = rec_i[ch*REC_W +: REC_W];
      assign col_slc[ch] = ch_rec[idx_i];
    end
  endgenerate

  // Trailer slices: hit field low, bunch-crossing field high.
  genvar j;
  generate
    for (j = 0; j < N_MRG; j++) begin : g_mrg
      assign mrg_slc[j] = {bcn_i[j*BCN_PER +: BCN_PER], hit_i[j*HIT_PER +: HIT_PER]};
    end
  endgenerate

  always_comb begin
    slice_o = col_slc;
    for (int m = 0; m < N_MRG; m++) begin
      if (idx_i == IDX_W'(REC_W + m)) slice_o = mrg_slc[m];
    end
  end
endmodule

// File: rtl/rdo_seq_ctrl.sv
module rdo_seq_ctrl
  import rdo_pkg::*;
#(
  parameter int N_SLC = 83,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             load_o,
  output logic             valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLC - 1);

  fmt_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             accept;

  assign accept = (state_q == ST_SEND) && ready_i;

  // Next-state process
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_SEND;
          idx_d   = '0;
        end
      end
      ST_SEND: begin
        if (accept) begin
          if (idx_q == LAST_IDX) begin
            state_d = ST_IDLE;
            idx_d   = '0;
            done_d  = 1'b1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  assign valid_o = (state_q == ST_SEND);
  assign busy_o  = (state_q == ST_SEND);
  assign done_o  = done_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/rdo_slice_fmt.sv
module rdo_slice_fmt #(
  parameter int N_CH    = 20,
  parameter int REC_W   = 80,
  parameter int HIT_W   = 48,
  parameter int BCN_W   = 12,
  parameter int HIT_PER = 16,
  parameter int BCN_PER = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [N_CH*REC_W-1:0]  ser_data_i,
  input  logic [HIT_W-1:0]       hit_i,
  input  logic [BCN_W-1:0]       bcn_i,
  input  logic                   slc_ready_i,
  output logic [N_CH-1:0]        slc_data_o,
  output logic                   slc_valid_o,
  output logic                   busy_o,
  output logic                   done_o
);
  localparam int N_MRG = HIT_W / HIT_PER;
  localparam int N_SLC = REC_W + N_MRG;
  localparam int IDX_W = $clog2(N_SLC);

  logic                  rst_int_n;
  logic                  load;
  logic [IDX_W-1:0]      idx;
  logic [N_CH*REC_W-1:0] rec_q;
  logic [HIT_W-1:0]      hit_q;
  logic [BCN_W-1:0]      bcn_q;

  rdo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rdo_seq_ctrl #(.N_SLC(N_SLC), .IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .ready_i (slc_ready_i),
    .load_o  (load),
    .valid_o (slc_valid_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .idx_o   (idx)
  );

  rdo_event_capture #(.N_CH(N_CH), .REC_W(REC_W), .HIT_W(HIT_W), .BCN_W(BCN_W)) u_cap (
    .clk    (clk),
    .load_i (load),
    .ser_i  (ser_data_i),
    .hit_i  (hit_i),
    .bcn_i  (bcn_i),
    .rec_o  (rec_q),
    .hit_o  (hit_q),
    .bcn_o  (bcn_q)
  );

  rdo_slice_select #(
    .N_CH(N_CH), .REC_W(REC_W), .HIT_W(HIT_W), .BCN_W(BCN_W),
    .HIT_PER(HIT_PER), .BCN_PER(BCN_PER), .IDX_W(IDX_W)
  ) u_sel (
    .idx_i   (idx),
    .rec_i   (rec_q),
    .hit_i   (hit_q),
    .bcn_i   (bcn_q),
    .slice_o (slc_data_o)
  );
endmodule

// File: rtl/rdo_slice_fmt_chk.sv
module rdo_slice_fmt_chk #(
  parameter int N_CH  = 20,
  parameter int N_SLC = 83
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            slc_ready_i,
  input logic [N_CH-1:0] slc_data_o,
  input logic            slc_valid_o,
  input logic            busy_o,
  input logic            done_o
);
  localparam int CNT_W = $clog2(N_SLC + 1);

  logic [CNT_W-1:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        beats <= '0;
    else if (!busy_o && start_i)       beats <= '0;
    else if (slc_valid_o && slc_ready_i) beats <= beats + CNT_W'(1);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    slc_valid_o && !slc_ready_i |=> slc_valid_o && $stable(slc_data_o)); // R5

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> beats == CNT_W'(N_SLC) && !busy_o); // R8

  AST_END_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R7

  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> beats < CNT_W'(N_SLC)); // R4
endmodule

bind rdo_slice_fmt rdo_slice_fmt_chk #(.N_CH(N_CH), .N_SLC(N_SLC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .slc_ready_i (slc_ready_i),
  .slc_data_o  (slc_data_o),
  .slc_valid_o (slc_valid_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/rdo_slice_fmt_test.sv
module rdo_slice_fmt_test;
  localparam int N_CH  = 20;
  localparam int REC_W = 80;
  localparam int HIT_W = 48;
  localparam int BCN_W = 12;
  localparam int N_SLC = 83;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  start_i;
  logic [N_CH*REC_W-1:0] ser_data_i;
  logic [HIT_W-1:0]      hit_i;
  logic [BCN_W-1:0]      bcn_i;
  logic                  slc_ready_i;
  logic [N_CH-1:0]       slc_data_o;
  logic                  slc_valid_o;
  logic                  busy_o;
  logic                  done_o;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  rdo_slice_fmt uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ser_data_i(ser_data_i),
    .hit_i(hit_i), .bcn_i(bcn_i), .slc_ready_i(slc_ready_i),
    .slc_data_o(slc_data_o), .slc_valid_o(slc_valid_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // Reference model state
  bit              m_busy = 0;
  bit              m_done = 0;
  int              m_pos  = 0;
  logic [N_CH-1:0] m_q[$];

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (%s, phase %s) cycle %0d: actual=%h expected=%h", req, what, phase, cycles, act, exp);
    end
  endtask

  function automatic void build_event();
    m_q.delete();
    for (int k = 0; k < REC_W; k++) begin
      logic [N_CH-1:0] s;
      for (int i = 0; i < N_CH; i++) s[i] = ser_data_i[i*REC_W + k];
      m_q.push_back(s);
    end
    for (int j = 0; j < 3; j++)
      m_q.push_back({bcn_i[4*j +: 4], hit_i[16*j +: 16]});
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Compare, then advance the model with the inputs held for the next edge.
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_pos = 0; m_q.delete();
    end else begin
      check(m_busy ? "R6" : "R8", "valid", 32'(slc_valid_o), 32'(m_busy));
      check(m_busy ? "R2" : "R7", "busy",  32'(busy_o),      32'(m_busy));
      check("R8", "done", 32'(done_o), 32'(m_done));
      if (m_busy)
        check(m_pos < REC_W ? "R3" : "R4", "data", 32'(slc_data_o), 32'(m_q[0]));
      m_done = 0;
      if (m_busy) begin
        if (slc_ready_i) begin
          void'(m_q.pop_front());
          m_pos++;
          if (m_q.size() == 0) begin
            m_busy = 0;
            m_done = 1;
            if (m_pos != N_SLC) check("R4", "slice count", 32'(m_pos), 32'(N_SLC));
          end
        end
      end else if (start_i) begin
        build_event();
        m_busy = 1;
        m_pos  = 0;
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic fill_inputs();
    for (int b = 0; b < N_CH*REC_W; b++) ser_data_i[b] = 1'($urandom);
    hit_i = {16'($urandom), 32'($urandom)};
    bcn_i = 12'($urandom);
  endtask

  task automatic wait_idle();
    while (m_busy || m_done) step();
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; slc_ready_i = 1'b0;
    ser_data_i = '0; hit_i = '0; bcn_i = '0;
    repeat (3) step();
    phase = "R1";
    check("R1", "valid at reset", 32'(slc_valid_o), 0);
    check("R1", "busy at reset",  32'(busy_o), 0);
    check("R1", "done at reset",  32'(done_o), 0);
    rst_n = 1'b1;
    repeat (4) step();

    // Event A: fixed corner patterns, downstream always ready
    phase = "R3";
    for (int i = 0; i < N_CH; i++) ser_data_i[i*REC_W +: REC_W] = (i % 2) ? {40{2'b10}} : {80{1'b1}};
    hit_i = 48'hA5A5_0F0F_FFFF; bcn_i = 12'hC3A;
    slc_ready_i = 1'b1;
    start_i = 1'b1; step(); start_i = 1'b0;
    wait_idle();
    repeat (3) step();

    // Event B: stalls, input changes and start pulses mid transfer
    phase = "R5";
    fill_inputs();
    slc_ready_i = 1'b0;
    start_i = 1'b1; step(); start_i = 1'b0;
    repeat (6) step();            // long stall on slice 0
    phase = "R9";
    fill_inputs();                // new inputs must not leak in
    for (int c = 0; c < 400 && (m_busy || m_done); c++) begin
      slc_ready_i = 1'($urandom);
      phase   = (c % 7 == 3) ? "R7" : "R6";
      start_i = (c % 7 == 3);
      if (c % 11 == 5) fill_inputs();
      step();
    end
    start_i = 1'b0; slc_ready_i = 1'b1;
    wait_idle();

    // Event C: start held through the end; ignored at last accept, taken at done
    phase = "R10";
    fill_inputs();
    slc_ready_i = 1'b1;
    start_i = 1'b1;
    while (!m_done) step();       // start high through slice 82 acceptance
    step();                       // done cycle: start still high, accepted
    start_i = 1'b0;
    fill_inputs();
    for (int c = 0; c < 300 && (m_busy || m_done); c++) begin
      slc_ready_i = (c % 3 != 1);
      step();
    end
    wait_idle();
    repeat (3) step();
    summary();
  end
endmodule